// File: doc/BRIEF.md
# Masked GPIO Port Register Block

This block is a memory-mapped general-purpose I/O controller with two independent 32-pin ports behind a simple synchronous register bus. Each port holds a direction register, an output latch and a mask. Software can change pins in several ways. It can write the whole port through the pin register, and the mask limits that write to the unmasked pins. It can write a word to the set, clear or toggle register, which changes only the pins whose bit is 1. It can also write the byte register that each pin owns. None of these updates needs a read-modify-write sequence.

Pad inputs pass through a two-flop synchronizer before software can read them. The pin register returns, for each pin, the output latch when the pin is an output and the synchronized pad when it is an input. A masked pin reads as 0. Read data is registered: the value for the address on the bus appears on `bus_rdata` one clock later.

The word address has three fields. Bit 6 selects the port. Bit 5 selects between the control registers (0) and the per-pin byte registers (1). Bits 4:0 give the register selector or the pin number. The control selectors are 0 direction, 1 pin, 2 mask, 3 set, 4 clear and 5 toggle. In the pads, port 0 occupies bits 31:0 and port 1 occupies bits 63:32.

Top module: `gpio_masked_ports`

## Requirements
- R1: On reset, every direction, mask and latch bit is 0. While reset is held, `pad_out`, `pad_oe` and `bus_rdata` are all 0.
- R2: Writing the direction register (selector 0) drives the port's `pad_oe` bits from the written word, where 1 means output. The register reads back the value written. `pad_oe` changes only on such a write.
- R3: Writing the set register (selector 3) drives high each latch whose write bit is 1 and leaves every other latch unchanged.
- R4: Writing the clear register (selector 4) drives low each latch whose write bit is 1 and leaves every other latch unchanged.
- R5: Writing the toggle register (selector 5) inverts each latch whose write bit is 1 and leaves every other latch unchanged.
- R6: A write to the pin register (selector 1) loads only the latches whose mask bit is 0. Latches whose mask bit is 1 keep their value, including when every pin is masked.
- R7: A pin-register read returns 0 for each masked pin. An unmasked input pin returns the synchronized pad value and an unmasked output pin returns its latch. A pad change reaches `bus_rdata` on the third rising edge after it, and is not visible after the second.
- R8: Writing the byte register at offset 32+n loads latch n with 0 when the written word is zero and with 1 otherwise, and leaves the other pins unchanged. Reading it returns pin n's state in bit 0 regardless of the mask.
- R9: The two ports are independent. A write to one port never changes the other port's pads or registers.
- R10: Reads of the set, clear and toggle selectors and of unused selectors 6 to 31 return 0. Writes to unused selectors change nothing.
- R11: The mask register (selector 2) reads back the value written, and it resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Word address: port, region, selector or pin |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | 64 | Asynchronous pad inputs, port 1 in the upper half |
| pad_out | output | 64 | Output latches |
| pad_oe | output | 64 | Output enables (direction register) |

## Verification
A wrong latch or direction bit shows at `pad_out` or `pad_oe` on the clock edge right after the write that caused it, so each write is checked against the pads before the next access. Wrong mask state is invisible at the pads until a pin-register write or read. The bench therefore follows every mask change with a masked write and a read, and the error appears one cycle after that read. A synchronizer that is one stage too short or too long shifts the moment an input change reaches the read data by one edge, and the bench tests the exact edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [2:0] {
        REG_DIR  = 3'd0,
        REG_PIN  = 3'd1,
        REG_MASK = 3'd2,
        REG_SET  = 3'd3,
        REG_CLR  = 3'd4,
        REG_TOG  = 3'd5
    } reg_sel_e;

    localparam int REG_CNT = 6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= async_in;
            sync_out <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int PIN_W = 32,
    localparam int IDX_W = $clog2(PIN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_byte,
    input  reg_sel_e         wr_sel,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PIN_W-1:0] wr_data,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] mask_q,
    output logic [PIN_W-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            mask_q  <= '0;
            latch_q <= '0;
        end else if (wr_en) begin
            if (wr_byte) begin
                latch_q[wr_idx] <= |wr_data;
            end else begin
                unique case (wr_sel)
                    REG_DIR:  dir_q   <= wr_data;
                    REG_PIN:  latch_q <= (latch_q & mask_q) | (wr_data & ~mask_q);
                    REG_MASK: mask_q  <= wr_data;
                    REG_SET:  latch_q <= latch_q | wr_data;
                    REG_CLR:  latch_q <= latch_q & ~wr_data;
                    REG_TOG:  latch_q <= latch_q ^ wr_data;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_masked_ports.sv
module gpio_masked_ports
    import gpio_pkg::*;
#(
    parameter int PIN_W = 32,
    parameter int NPORT = 2,
    localparam int IDX_W  = $clog2(PIN_W),
    localparam int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int ADDR_W = PSEL_W + 1 + IDX_W,
    localparam int PAD_W  = PIN_W * NPORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PAD_W-1:0]  pad_in,
    output logic [PAD_W-1:0]  pad_out,
    output logic [PAD_W-1:0]  pad_oe
);
    logic [PSEL_W-1:0] port_sel;
    logic              byte_rgn;
    logic [IDX_W-1:0]  idx;
    logic              sel_ok;
    reg_sel_e          sel;
    logic [PAD_W-1:0]  pad_sync;

    logic [PIN_W-1:0] dir_a   [NPORT];
    logic [PIN_W-1:0] mask_a  [NPORT];
    logic [PIN_W-1:0] latch_a [NPORT];
    logic [PIN_W-1:0] raw_a   [NPORT];

    assign port_sel = bus_addr[ADDR_W-1 -: PSEL_W];
    assign byte_rgn = bus_addr[IDX_W];
    assign idx      = bus_addr[IDX_W-1:0];
    assign sel_ok   = idx < IDX_W'(REG_CNT);
    assign sel      = reg_sel_e'(idx[2:0]);

    gpio_sync #(.W(PAD_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic wr_hit;
        assign wr_hit = bus_we && (port_sel == PSEL_W'(p)) && (byte_rgn || sel_ok);

        gpio_port #(.PIN_W(PIN_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_byte (byte_rgn),
            .wr_sel  (sel),
            .wr_idx  (idx),
            .wr_data (bus_wdata),
            .dir_q   (dir_a[p]),
            .mask_q  (mask_a[p]),
            .latch_q (latch_a[p])
        );

        assign raw_a[p] = (dir_a[p] & latch_a[p]) |
                          (~dir_a[p] & pad_sync[p*PIN_W +: PIN_W]);
        assign pad_out[p*PIN_W +: PIN_W] = latch_a[p];
        assign pad_oe[p*PIN_W +: PIN_W]  = dir_a[p];
    end

    logic [PIN_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (int'(port_sel) < NPORT) begin
            if (byte_rgn) begin
                rd_next[0] = raw_a[port_sel][idx];
            end else if (sel_ok) begin
                unique case (sel)
                    REG_DIR:  rd_next = dir_a[port_sel];
                    REG_PIN:  rd_next = raw_a[port_sel] & ~mask_a[port_sel];
                    REG_MASK: rd_next = mask_a[port_sel];
                    default:  rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_masked_ports_chk.sv
module gpio_masked_ports_chk #(
    parameter int PIN_W  = 32,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [PIN_W-1:0]  pad_out0,
    input logic [PIN_W-1:0]  pad_oe0
);
    localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_TOG0 = ADDR_W'(5);

    a_r2_oe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_DIR0) |=> $stable(pad_oe0));

    a_r3_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SET0) |=> ((pad_out0 & $past(bus_wdata)) == $past(bus_wdata)));

    a_r4_clr_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLR0) |=> ((pad_out0 & $past(bus_wdata)) == '0));

    a_r5_tog_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_TOG0) |=> (pad_out0 == ($past(pad_out0) ^ $past(bus_wdata))));

    a_r10_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SET0) |=> (bus_rdata == '0));
endmodule

bind gpio_masked_ports gpio_masked_ports_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out0  (pad_out[PIN_W-1:0]),
    .pad_oe0   (pad_oe[PIN_W-1:0])
);

// File: tb/gpio_masked_ports_bench.sv
module gpio_masked_ports_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pad_in = 64'h0F0F_3C3C_A5A5_F00F;
    logic [63:0] pad_out;
    logic [63:0] pad_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_masked_ports u_gpio_masked_ports (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [6:0]  waddr;
        logic        we;
        logic [31:0] wdata;
        logic [6:0]  raddr;
        logic [31:0] rexp;
        logic [63:0] oexp;
        logic [63:0] eexp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{4'd2,  7'h00, 1'b1, 32'hFFFF_0000, 7'h00, 32'hFFFF_0000, 64'h0, 64'h0000_0000_FFFF_0000},             // R2
        '{4'd3,  7'h03, 1'b1, 32'h1234_00FF, 7'h01, 32'h1234_F00F, 64'h0000_0000_1234_00FF, 64'h0000_0000_FFFF_0000}, // R3
        '{4'd4,  7'h04, 1'b1, 32'h0030_000F, 7'h01, 32'h1204_F00F, 64'h0000_0000_1204_00F0, 64'h0000_0000_FFFF_0000}, // R4
        '{4'd5,  7'h05, 1'b1, 32'hFF00_0001, 7'h01, 32'hED04_F00F, 64'h0000_0000_ED04_00F1, 64'h0000_0000_FFFF_0000}, // R5
        '{4'd11, 7'h02, 1'b1, 32'h00FF_00FF, 7'h02, 32'h00FF_00FF, 64'h0000_0000_ED04_00F1, 64'h0000_0000_FFFF_0000}, // R11
        '{4'd6,  7'h01, 1'b1, 32'h5555_5555, 7'h01, 32'h5500_F000, 64'h0000_0000_5504_55F1, 64'h0000_0000_FFFF_0000}, // R6 R7
        '{4'd8,  7'h24, 1'b1, 32'h0000_0000, 7'h24, 32'h0000_0000, 64'h0000_0000_5504_55E1, 64'h0000_0000_FFFF_0000}, // R8
        '{4'd8,  7'h3F, 1'b1, 32'h0000_0080, 7'h3F, 32'h0000_0001, 64'h0000_0000_D504_55E1, 64'h0000_0000_FFFF_0000}, // R8
        '{4'd9,  7'h40, 1'b1, 32'h0000_FFFF, 7'h41, 32'h0F0F_0000, 64'h0000_0000_D504_55E1, 64'h0000_FFFF_FFFF_0000}, // R9
        '{4'd9,  7'h43, 1'b1, 32'h8000_00A5, 7'h41, 32'h0F0F_00A5, 64'h8000_00A5_D504_55E1, 64'h0000_FFFF_FFFF_0000}, // R9
        '{4'd10, 7'h03, 1'b1, 32'h0000_0002, 7'h03, 32'h0000_0000, 64'h8000_00A5_D504_55E3, 64'h0000_FFFF_FFFF_0000}, // R10
        '{4'd10, 7'h07, 1'b1, 32'hFFFF_FFFF, 7'h07, 32'h0000_0000, 64'h8000_00A5_D504_55E3, 64'h0000_FFFF_FFFF_0000}, // R10
        '{4'd11, 7'h00, 1'b0, 32'hFFFF_FFFF, 7'h02, 32'h00FF_00FF, 64'h8000_00A5_D504_55E3, 64'h0000_FFFF_FFFF_0000}, // R11
        '{4'd7,  7'h02, 1'b1, 32'h0000_0000, 7'h01, 32'hD504_F00F, 64'h8000_00A5_D504_55E3, 64'h0000_FFFF_FFFF_0000}  // R7
    };

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 pad_out", pad_out, 64'h0);
        check("R1 pad_oe", pad_oe, 64'h0);
        check("R1 rdata", {32'h0, bus_rdata}, 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(7'h02);
        check("R11 mask reset", {32'h0, bus_rdata}, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].we) bus_write(VEC[i].waddr, VEC[i].wdata);
            bus_read(VEC[i].raddr);
            check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), {32'h0, bus_rdata}, {32'h0, VEC[i].rexp});
            check($sformatf("R%0d vec%0d pad_out", VEC[i].req, i), pad_out, VEC[i].oexp);
            check($sformatf("R%0d vec%0d pad_oe", VEC[i].req, i), pad_oe, VEC[i].eexp);
        end

        // R7: synchronizer latency, pad bit 0 of port 0 is an unmasked input
        bus_read(7'h01);
        pad_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 sync old after two edges", {32'h0, bus_rdata}, 64'hD504_F00F);
        @(negedge clk);
        check("R7 sync new after three edges", {32'h0, bus_rdata}, 64'hD504_F00E);

        // R6: all pins masked, pin write changes nothing
        bus_write(7'h02, 32'hFFFF_FFFF);
        bus_write(7'h01, 32'h0000_0000);
        check("R6 fully masked write", pad_out, 64'h8000_00A5_D504_55E3);
        bus_read(7'h01);
        check("R7 fully masked read", {32'h0, bus_rdata}, 64'h0);
        bus_read(7'h21);
        check("R8 byte read ignores mask", {32'h0, bus_rdata}, 64'h1);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pad_out after reset", pad_out, 64'h0);
        check("R1 pad_oe after reset", pad_oe, 64'h0);
        check("R1 rdata after reset", {32'h0, bus_rdata}, 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule